// File: doc/BRIEF.md
# Digital Potentiometer Wiper and Register Command Engine

This block is the command core behind a serial-bus front-end for a four-channel digital potentiometer. It keeps one wiper code for each pot and four stored settings for each pot. The stored settings are a register array that stands in for nonvolatile memory. The front-end has already decoded the bus traffic. It hands the engine the instruction byte, an optional data byte, single increment/decrement steps and the STOP event. The engine executes reads, writes, single and gang transfers and wiper stepping. It returns read data and acknowledges accepted data bytes.

Any command that changes a stored setting takes effect at STOP. It then holds a busy flag for a parameterised number of cycles, which models the nonvolatile programming time. While busy, the engine ignores all traffic. A write-enable input blocks every change to the stored settings. Wiper writes and loads into the wipers stay allowed while it is low. The stored settings keep their contents across reset. After reset, each wiper is reloaded from its pot's setting 0.

Top module: `potcmd_engine`

## Requirements
- R1: After reset, `busy_o`, `rd_vld_o` and `wdat_ack_o` are low. The stored settings keep their contents through reset. Once reset is released, each wiper takes the value of its own pot's setting 0.
- R2: The instruction byte carries the opcode in bits 7:4, the setting select in bits 3:2 and the pot select in bits 1:0. The opcodes are:
  - 1001: read wiper
  - 1010: write wiper
  - 1011: read setting
  - 1100: write setting
  - 1101: setting to wiper
  - 1110: wiper to setting
  - 0001: gang setting to wipers
  - 1000: gang wipers to settings
  - 0010: increment/decrement

  Any other opcode is ignored, along with any data byte, step or STOP that follows it.
- R3: A read-wiper instruction raises `rd_vld_o` for one cycle, one cycle after the instruction. `rd_dat_o` then holds the selected pot's wiper.
- R4: A read-setting instruction does the same with the setting chosen by the pot and setting selects.
- R5: The data byte of a write-wiper command loads the selected wiper one cycle after the byte. `wdat_ack_o` pulses in that same cycle, whatever the level of `nv_wr_en_i`.
- R6: The data byte of a write-setting command is held until STOP, and only then written to the selected setting. `wdat_ack_o` pulses for that byte only when `nv_wr_en_i` is high. When `nv_wr_en_i` is low, the byte gets no acknowledge and the setting keeps its value.
- R7: A setting-to-wiper transfer loads the wiper at STOP and does not raise busy. A wiper-to-setting transfer writes the setting at STOP and starts busy.
- R8: Gang transfers use the setting select and act on all four pots at STOP, ignoring the pot select. Only the wipers-to-settings direction starts busy.
- R9: After an increment/decrement instruction, each step moves the selected wiper by one, up when `step_up_i` is high and down otherwise. The wiper holds at all-ones when stepping up and at zero when stepping down.
- R10: `busy_o` rises in the cycle after STOP and stays high for exactly BUSY_CYCLES cycles. It does so only when that STOP changes a stored setting.
- R11: While `busy_o` is high, every input event is ignored: no read response, no acknowledge and no change to wipers or settings.
- R12: A setting update happens only if `nv_wr_en_i` is high at STOP. Dropping it between the data byte and STOP cancels the update, and no busy window starts.
- R13: STOP ends the current command. Data bytes and steps that arrive after it, before a new instruction, are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nv_wr_en_i | input | 1 | Stored-setting update enable (low blocks) |
| cmd_vld_i | input | 1 | Instruction byte strobe |
| cmd_byte_i | input | 8 | Instruction byte |
| wdat_vld_i | input | 1 | Data byte strobe |
| wdat_i | input | WIDTH | Data byte |
| step_vld_i | input | 1 | Increment/decrement step strobe |
| step_up_i | input | 1 | Step direction, high = up |
| stop_i | input | 1 | STOP seen on the bus |
| rd_vld_o | output | 1 | Read data valid pulse |
| rd_dat_o | output | WIDTH | Read data |
| wdat_ack_o | output | 1 | Data byte accepted pulse |
| busy_o | output | 1 | Nonvolatile write in progress |
| wipers_o | output | 4*WIDTH | Wiper codes, pot 0 in the low bits |

## Verification
Some behaviour is checked by assertions on every cycle:
- the wiper codes stay frozen and no read response appears while busy;
- a blocked STOP never opens a busy window;
- every acknowledge and read pulse traces back to an accepted byte;
- each step moves a wiper by exactly one or holds it at a limit.

Other behaviour shows up only in the bench scenarios:
- the exact busy length;
- the deferral of setting writes until STOP;
- gang transfers across all four pots;
- write-enable dropping between data and STOP;
- the reload of wipers from setting 0 after reset.

// File: rtl/potcmd_pkg.sv
package potcmd_pkg;
  localparam int NUM_POTS = 4;
  localparam int NUM_DR   = 4;
  localparam int SEL_W    = 2;

  typedef enum logic [3:0] {
    OP_NONE      = 4'b0000,
    OP_GANG_DR2W = 4'b0001,
    OP_INCDEC    = 4'b0010,
    OP_GANG_W2DR = 4'b1000,
    OP_RD_W      = 4'b1001,
    OP_WR_W      = 4'b1010,
    OP_RD_DR     = 4'b1011,
    OP_WR_DR     = 4'b1100,
    OP_DR2W      = 4'b1101,
    OP_W2DR      = 4'b1110
  } op_e;

  typedef struct packed {
    op_e              op;
    logic [SEL_W-1:0] rsel;
    logic [SEL_W-1:0] psel;
  } cmd_t;
endpackage

// File: rtl/potcmd_decode.sv
module potcmd_decode
  import potcmd_pkg::*;
(
  input  logic [7:0] byte_i,
  output cmd_t       cmd_o
);
  always_comb begin
    cmd_o.rsel = byte_i[3:2];
    cmd_o.psel = byte_i[1:0];
    case (byte_i[7:4])
      4'b0001: cmd_o.op = OP_GANG_DR2W;
      4'b0010: cmd_o.op = OP_INCDEC;
      4'b1000: cmd_o.op = OP_GANG_W2DR;
      4'b1001: cmd_o.op = OP_RD_W;
      4'b1010: cmd_o.op = OP_WR_W;
      4'b1011: cmd_o.op = OP_RD_DR;
      4'b1100: cmd_o.op = OP_WR_DR;
      4'b1101: cmd_o.op = OP_DR2W;
      4'b1110: cmd_o.op = OP_W2DR;
      default: cmd_o.op = OP_NONE;
    endcase
  end
endmodule

// File: rtl/potcmd_nv_timer.sv
module potcmd_nv_timer #(
  parameter int BUSY_CYCLES = 2_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start_i && !busy_o) begin
      cnt_d = CNT_W'(BUSY_CYCLES);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);

  p_busy_onset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);
  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(BUSY_CYCLES));
endmodule

// File: rtl/potcmd_wiper_cell.sv
module potcmd_wiper_cell #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             recall_i,
  input  logic [WIDTH-1:0] recall_val_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  input  logic             step_i,
  input  logic             up_i,
  output logic [WIDTH-1:0] val_o
);
  logic [WIDTH-1:0] val_q, val_d;

  always_comb begin
    val_d = val_q;
    if (recall_i) begin
      val_d = recall_val_i;
    end else if (load_i) begin
      val_d = load_val_i;
    end else if (step_i) begin
      if (up_i && (val_q != '1))       val_d = val_q + WIDTH'(1);
      else if (!up_i && (val_q != '0)) val_d = val_q - WIDTH'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= val_d;
  end

  assign val_o = val_q;

  p_sat_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && up_i && !load_i && !recall_i && val_q == '1) |=> (val_q == '1));
  p_sat_bot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !up_i && !load_i && !recall_i && val_q == '0) |=> (val_q == '0));
  p_step_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && up_i && !load_i && !recall_i && val_q != '1)
      |=> (val_q == $past(val_q) + WIDTH'(1)));
  p_step_dn_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !up_i && !load_i && !recall_i && val_q != '0)
      |=> (val_q == $past(val_q) - WIDTH'(1)));
endmodule

// File: rtl/potcmd_engine.sv
module potcmd_engine
  import potcmd_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int BUSY_CYCLES = 2_500_000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      nv_wr_en_i,
  input  logic                      cmd_vld_i,
  input  logic [7:0]                cmd_byte_i,
  input  logic                      wdat_vld_i,
  input  logic [WIDTH-1:0]          wdat_i,
  input  logic                      step_vld_i,
  input  logic                      step_up_i,
  input  logic                      stop_i,
  output logic                      rd_vld_o,
  output logic [WIDTH-1:0]          rd_dat_o,
  output logic                      wdat_ack_o,
  output logic                      busy_o,
  output logic [NUM_POTS*WIDTH-1:0] wipers_o
);
  // reset release synchroniser
  logic [1:0] rs_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  // decoded instruction
  cmd_t dec;
  potcmd_decode u_dec (.byte_i(cmd_byte_i), .cmd_o(dec));

  // state
  op_e              op_q, op_d;
  logic [SEL_W-1:0] r_q, r_d, p_q, p_d;
  logic             live_q, live_d, pend_q, pend_d;
  logic [WIDTH-1:0] pval_q, pval_d;
  logic             rd_vld_d, ack_d;
  logic [WIDTH-1:0] rd_dat_d;
  logic             recall_q;

  logic [WIDTH-1:0] dr_q  [NUM_POTS][NUM_DR];
  logic [WIDTH-1:0] dr_wd [NUM_POTS][NUM_DR];
  logic [NUM_POTS-1:0][NUM_DR-1:0] dr_we;

  logic [WIDTH-1:0]    wip [NUM_POTS];
  logic [WIDTH-1:0]    wip_ldv [NUM_POTS];
  logic [NUM_POTS-1:0] wip_ld, wip_step;
  logic                nv_start, accept;

  assign accept = !busy_o && !recall_q;

  always_comb begin
    op_d     = op_q;
    r_d      = r_q;
    p_d      = p_q;
    live_d   = live_q;
    pend_d   = pend_q;
    pval_d   = pval_q;
    rd_vld_d = 1'b0;
    rd_dat_d = rd_dat_o;
    ack_d    = 1'b0;
    nv_start = 1'b0;
    wip_ld   = '0;
    wip_step = '0;
    dr_we    = '0;
    for (int i = 0; i < NUM_POTS; i++) begin
      wip_ldv[i] = '0;
      for (int j = 0; j < NUM_DR; j++) dr_wd[i][j] = '0;
    end

    if (accept) begin
      if (stop_i) begin
        if (live_q) begin
          case (op_q)
            OP_WR_DR: if (pend_q && nv_wr_en_i) begin
              dr_we[p_q][r_q] = 1'b1;
              dr_wd[p_q][r_q] = pval_q;
              nv_start        = 1'b1;
            end
            OP_W2DR: if (nv_wr_en_i) begin
              dr_we[p_q][r_q] = 1'b1;
              dr_wd[p_q][r_q] = wip[p_q];
              nv_start        = 1'b1;
            end
            OP_GANG_W2DR: if (nv_wr_en_i) begin
              for (int i = 0; i < NUM_POTS; i++) begin
                dr_we[i][r_q] = 1'b1;
                dr_wd[i][r_q] = wip[i];
              end
              nv_start = 1'b1;
            end
            OP_DR2W: begin
              wip_ld[p_q]  = 1'b1;
              wip_ldv[p_q] = dr_q[p_q][r_q];
            end
            OP_GANG_DR2W: begin
              for (int i = 0; i < NUM_POTS; i++) begin
                wip_ld[i]  = 1'b1;
                wip_ldv[i] = dr_q[i][r_q];
              end
            end
            default: ;
          endcase
        end
        live_d = 1'b0;
        pend_d = 1'b0;
      end else if (cmd_vld_i) begin
        op_d   = dec.op;
        r_d    = dec.rsel;
        p_d    = dec.psel;
        live_d = (dec.op != OP_NONE);
        pend_d = 1'b0;
        if (dec.op == OP_RD_W) begin
          rd_vld_d = 1'b1;
          rd_dat_d = wip[dec.psel];
        end else if (dec.op == OP_RD_DR) begin
          rd_vld_d = 1'b1;
          rd_dat_d = dr_q[dec.psel][dec.rsel];
        end
      end else if (wdat_vld_i && live_q) begin
        if (op_q == OP_WR_W) begin
          wip_ld[p_q]  = 1'b1;
          wip_ldv[p_q] = wdat_i;
          ack_d        = 1'b1;
        end else if (op_q == OP_WR_DR && nv_wr_en_i) begin
          pend_d = 1'b1;
          pval_d = wdat_i;
          ack_d  = 1'b1;
        end
      end else if (step_vld_i && live_q && op_q == OP_INCDEC) begin
        wip_step[p_q] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q       <= OP_NONE;
      r_q        <= '0;
      p_q        <= '0;
      live_q     <= 1'b0;
      pend_q     <= 1'b0;
      pval_q     <= '0;
      rd_vld_o   <= 1'b0;
      rd_dat_o   <= '0;
      wdat_ack_o <= 1'b0;
      recall_q   <= 1'b1;
    end else begin
      op_q       <= op_d;
      r_q        <= r_d;
      p_q        <= p_d;
      live_q     <= live_d;
      pend_q     <= pend_d;
      pval_q     <= pval_d;
      rd_vld_o   <= rd_vld_d;
      rd_dat_o   <= rd_dat_d;
      wdat_ack_o <= ack_d;
      recall_q   <= 1'b0;
    end
  end

  // stored settings: no reset, they model nonvolatile cells
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_POTS; i++) begin
      for (int j = 0; j < NUM_DR; j++) begin
        if (dr_we[i][j]) dr_q[i][j] <= dr_wd[i][j];
      end
    end
  end

  potcmd_nv_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_ni), .start_i(nv_start), .busy_o(busy_o)
  );

  for (genvar g = 0; g < NUM_POTS; g++) begin : g_pot
    potcmd_wiper_cell #(.WIDTH(WIDTH)) u_cell (
      .clk(clk), .rst_n(rst_ni),
      .recall_i(recall_q), .recall_val_i(dr_q[g][0]),
      .load_i(wip_ld[g]), .load_val_i(wip_ldv[g]),
      .step_i(wip_step[g]), .up_i(step_up_i),
      .val_o(wip[g])
    );
    assign wipers_o[g*WIDTH +: WIDTH] = wip[g];
  end

  p_busy_freeze_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    busy_o |=> $stable(wipers_o));
  p_busy_no_read_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    busy_o |=> !rd_vld_o);
  p_blocked_stop_r12: assert property (@(posedge clk) disable iff (!rst_ni)
    (stop_i && !nv_wr_en_i && !busy_o && !recall_q) |=> !busy_o);
  p_ack_cause_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    wdat_ack_o |-> $past(wdat_vld_i && !busy_o));
  p_rd_cause_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    rd_vld_o |-> $past(cmd_vld_i && !busy_o));
endmodule

// File: tb/potcmd_engine_bench.sv
module potcmd_engine_bench;
  localparam int W  = 8;
  localparam int BC = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nv_wr_en_i = 1'b1;
  logic cmd_vld_i = 1'b0;
  logic [7:0] cmd_byte_i = '0;
  logic wdat_vld_i = 1'b0;
  logic [W-1:0] wdat_i = '0;
  logic step_vld_i = 1'b0;
  logic step_up_i = 1'b0;
  logic stop_i = 1'b0;
  logic rd_vld_o, wdat_ack_o, busy_o;
  logic [W-1:0] rd_dat_o;
  logic [4*W-1:0] wipers_o;

  int n_tests = 0;
  int n_fail = 0;
  logic [W-1:0] exp_w [4];
  logic [W-1:0] exp_dr [4][4];

  always #2 clk = ~clk;

  potcmd_engine #(.WIDTH(W), .BUSY_CYCLES(BC)) u_potcmd_engine (
    .clk(clk), .rst_n(rst_n), .nv_wr_en_i(nv_wr_en_i),
    .cmd_vld_i(cmd_vld_i), .cmd_byte_i(cmd_byte_i),
    .wdat_vld_i(wdat_vld_i), .wdat_i(wdat_i),
    .step_vld_i(step_vld_i), .step_up_i(step_up_i), .stop_i(stop_i),
    .rd_vld_o(rd_vld_o), .rd_dat_o(rd_dat_o), .wdat_ack_o(wdat_ack_o),
    .busy_o(busy_o), .wipers_o(wipers_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int wip(input int i);
    return int'(wipers_o[i*W +: W]);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic p_cmd(input logic [7:0] b);
    @(negedge clk); cmd_vld_i = 1'b1; cmd_byte_i = b;
    @(negedge clk); cmd_vld_i = 1'b0;
  endtask
  task automatic p_data(input logic [W-1:0] d);
    @(negedge clk); wdat_vld_i = 1'b1; wdat_i = d;
    @(negedge clk); wdat_vld_i = 1'b0;
  endtask
  task automatic p_step(input logic up);
    @(negedge clk); step_vld_i = 1'b1; step_up_i = up;
    @(negedge clk); step_vld_i = 1'b0;
  endtask
  task automatic p_stop();
    @(negedge clk); stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
  endtask
  // counts busy cycles right after a STOP pulse
  task automatic busy_len(output int n);
    n = 0;
    while (busy_o && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic wr_dr(input int p, input int r, input logic [W-1:0] v, input string tag);
    int n;
    p_cmd({4'b1100, 2'(r), 2'(p)});
    p_data(v);
    chk({tag, " ack"}, int'(wdat_ack_o), 1);
    p_stop();
    busy_len(n);
    chk({tag, " busy len"}, n, BC);
    exp_dr[p][r] = v;
  endtask
  task automatic rd_dr(input int p, input int r, input string tag);
    p_cmd({4'b1011, 2'(r), 2'(p)});
    chk({tag, " rd_vld"}, int'(rd_vld_o), 1);
    chk({tag, " rd_dat"}, int'(rd_dat_o), int'(exp_dr[p][r]));
    p_stop();
  endtask
  task automatic wr_w(input int p, input logic [W-1:0] v);
    p_cmd({4'b1010, 2'b00, 2'(p)});
    p_data(v);
    p_stop();
    exp_w[p] = v;
  endtask

  // R1: reset state
  task automatic t_reset_state();
    do_reset();
    chk("R1 busy after reset", int'(busy_o), 0);
    chk("R1 rd_vld after reset", int'(rd_vld_o), 0);
    chk("R1 ack after reset", int'(wdat_ack_o), 0);
  endtask

  // R6 R4 R10: fill all settings and read them back
  task automatic t_fill_settings();
    for (int p = 0; p < 4; p++)
      for (int r = 0; r < 4; r++)
        wr_dr(p, r, W'(8'h10 * p + 8'h03 * r + 8'h21), "R10 R6 write setting");
    for (int p = 0; p < 4; p++)
      for (int r = 0; r < 4; r++)
        rd_dr(p, r, "R4 read setting");
  endtask

  // R1: recall from setting 0 after reset
  task automatic t_recall();
    do_reset();
    for (int i = 0; i < 4; i++) begin
      chk("R1 recall wiper", wip(i), int'(exp_dr[i][0]));
      exp_w[i] = exp_dr[i][0];
    end
    rd_dr(3, 2, "R1 setting kept through reset");
  endtask

  // R5 R3 R2: wiper write and read, also with write-enable low
  task automatic t_wiper_rw();
    p_cmd({4'b1010, 2'b00, 2'd1});
    p_data(8'h5A);
    chk("R5 ack", int'(wdat_ack_o), 1);
    chk("R5 wiper1", wip(1), 8'h5A);
    p_stop();
    exp_w[1] = 8'h5A;
    nv_wr_en_i = 1'b0;
    p_cmd({4'b1010, 2'b00, 2'd3});
    p_data(8'hC3);
    chk("R5 ack wp low", int'(wdat_ack_o), 1);
    p_stop();
    exp_w[3] = 8'hC3;
    nv_wr_en_i = 1'b1;
    chk("R5 wiper3 wp low", wip(3), 8'hC3);
    p_cmd({4'b1001, 2'b11, 2'd1});
    chk("R3 rd_vld", int'(rd_vld_o), 1);
    chk("R3 rd_dat", int'(rd_dat_o), 8'h5A);
    p_stop();
    chk("R3 rd_vld one cycle", int'(rd_vld_o), 0);
  endtask

  // R2: unknown opcode ignored
  task automatic t_bad_op();
    p_cmd(8'h31);
    chk("R2 bad op no rd", int'(rd_vld_o), 0);
    p_data(8'h77);
    chk("R2 bad op no ack", int'(wdat_ack_o), 0);
    p_stop();
    chk("R2 bad op no busy", int'(busy_o), 0);
    chk("R2 wiper1 unchanged", wip(1), int'(exp_w[1]));
  endtask

  // R6 R12: write-enable blocking
  task automatic t_protect();
    nv_wr_en_i = 1'b0;
    p_cmd({4'b1100, 2'd1, 2'd2});
    p_data(8'hEE);
    chk("R6 no ack wp low", int'(wdat_ack_o), 0);
    p_stop();
    chk("R6 no busy wp low", int'(busy_o), 0);
    nv_wr_en_i = 1'b1;
    rd_dr(2, 1, "R6 setting kept");
    p_cmd({4'b1100, 2'd1, 2'd2});
    p_data(8'hEE);
    chk("R12 ack wp high", int'(wdat_ack_o), 1);
    nv_wr_en_i = 1'b0;
    p_stop();
    chk("R12 no busy dropped", int'(busy_o), 0);
    nv_wr_en_i = 1'b1;
    rd_dr(2, 1, "R12 setting kept");
  endtask

  // R11: everything ignored while busy
  task automatic t_busy_ignore();
    p_cmd({4'b1100, 2'd3, 2'd0});
    p_data(8'h9C);
    p_stop();
    exp_dr[0][3] = 8'h9C;
    chk("R11 busy", int'(busy_o), 1);
    p_cmd({4'b1001, 2'b00, 2'd0});
    chk("R11 no read when busy", int'(rd_vld_o), 0);
    p_cmd({4'b1010, 2'b00, 2'd0});
    p_data(8'h01);
    chk("R11 no ack when busy", int'(wdat_ack_o), 0);
    p_stop();
    chk("R11 wiper0 unchanged", wip(0), int'(exp_w[0]));
    while (busy_o) @(negedge clk);
    rd_dr(0, 3, "R11 setting written");
  endtask

  // R7: single transfers
  task automatic t_xfer();
    int n;
    p_cmd({4'b1101, 2'd2, 2'd1});
    chk("R7 no load before stop", wip(1), int'(exp_w[1]));
    p_stop();
    exp_w[1] = exp_dr[1][2];
    chk("R7 setting to wiper", wip(1), int'(exp_w[1]));
    chk("R7 no busy", int'(busy_o), 0);
    wr_w(2, 8'hA5);
    p_cmd({4'b1110, 2'd3, 2'd2});
    p_stop();
    busy_len(n);
    chk("R7 wiper to setting busy", n, BC);
    exp_dr[2][3] = 8'hA5;
    rd_dr(2, 3, "R7 wiper to setting");
  endtask

  // R8: gang transfers
  task automatic t_gang();
    int n;
    for (int i = 0; i < 4; i++) wr_w(i, W'(8'h40 + 8'h11 * i));
    p_cmd({4'b1000, 2'd2, 2'd0});
    p_stop();
    busy_len(n);
    chk("R8 gang to settings busy", n, BC);
    for (int i = 0; i < 4; i++) begin
      exp_dr[i][2] = exp_w[i];
      rd_dr(i, 2, "R8 gang to settings");
    end
    for (int i = 0; i < 4; i++) wr_w(i, 8'h00);
    p_cmd({4'b0001, 2'd2, 2'd3});
    p_stop();
    chk("R8 gang to wipers no busy", int'(busy_o), 0);
    for (int i = 0; i < 4; i++) begin
      exp_w[i] = exp_dr[i][2];
      chk("R8 gang to wipers", wip(i), int'(exp_w[i]));
    end
  endtask

  // R9 R13: stepping and saturation
  task automatic t_incdec();
    wr_w(2, 8'hFD);
    p_cmd({4'b0010, 2'd0, 2'd2});
    p_step(1'b1); chk("R9 up 1", wip(2), 8'hFE);
    p_step(1'b1); chk("R9 up 2", wip(2), 8'hFF);
    p_step(1'b1); chk("R9 hold top", wip(2), 8'hFF);
    p_step(1'b0); p_step(1'b0);
    chk("R9 down 2", wip(2), 8'hFD);
    chk("R9 other pot untouched", wip(1), int'(exp_w[1]));
    p_stop();
    p_step(1'b1);
    chk("R13 step after stop", wip(2), 8'hFD);
    p_data(8'h12);
    chk("R13 data after stop no ack", int'(wdat_ack_o), 0);
    chk("R13 data after stop", wip(2), 8'hFD);
    wr_w(2, 8'h01);
    p_cmd({4'b0010, 2'd0, 2'd2});
    p_step(1'b0); p_step(1'b0);
    chk("R9 hold bottom", wip(2), 8'h00);
    p_stop();
  endtask

  bit done = 1'b0;
  initial begin
    t_reset_state();
    t_fill_settings();
    t_recall();
    t_wiper_rw();
    t_bad_op();
    t_protect();
    t_busy_ignore();
    t_xfer();
    t_gang();
    t_incdec();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule